// File: doc/BRIEF.md
# Paired Channel Enable Register

This block is one memory-mapped control word that holds the enable state of a set of channel pairs. Every pair has two alternative control packets, A and B. At most one of them is active, or the pair is off. Software does not store the state directly. It writes a two-bit command per pair, and the command either leaves the pair alone, selects packet A, selects packet B, or turns the pair off. A read returns the current state in a different two-bit encoding.

The block also keeps one pending-request flag per pair. The flag latches the pair's request line. When software brings a pair up from fully off, any stale request is thrown away, so only a request that comes after the enabling write can start the first transfer. Switching directly between packets keeps a pending request. A transfer engine outside the block gives per-pair auto-disable strobes and acknowledges. It uses the active-packet selects and the pending flags.

Top module: `pair_enable_reg`

## Requirements
- R1: After synchronous reset, every pair is off. All `sel_a`, `sel_b` and `pend` bits are 0, and `bus_rdata` is 0.
- R2: A privileged write to `REG_ADDR` applies the command in `bus_wdata[2x+1:2x]` to pair x at that clock edge. 2'b00 leaves the pair unchanged. 2'b01 selects A and deselects B. 2'b10 selects B and deselects A. 2'b11 turns both off. Both selects of a pair change at the same edge.
- R3: A read of `REG_ADDR` returns, one cycle later on `bus_rdata`, the pair state from before that edge. Bit 2x is 1 when A is active and bit 2x+1 is 1 when B is active. The value 2'b11 never appears, and `sel_a & sel_b` is never nonzero.
- R4: `bus_rdata` bits above 2*NUM_PAIRS are always 0. Write data in those bits has no effect. A read of any other address returns 0.
- R5: A write with `bus_priv` low, or to any address other than `REG_ADDR`, changes no pair. Reads work whatever the value of `bus_priv`.
- R6: `auto_dis[x]` high turns pair x off at the next edge. It wins over a write to the same pair in the same cycle.
- R7: `req[x]` high sets `pend[x]` at the next edge, whatever the pair state. `ack[x]` clears it. If both are high in the same cycle, `req` wins.
- R8: A write that moves pair x from off (00) to 01 or 10 clears `pend[x]`.
- R9: A write that switches pair x directly between A and B leaves `pend[x]` unchanged.
- R10: A request in the same cycle as an enabling write from off is kept, so `pend[x]` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data, two command bits per pair |
| bus_rdata | output | DATA_W | Registered read data |
| auto_dis | input | NUM_PAIRS | Per-pair forced disable from the transfer engine |
| req | input | NUM_PAIRS | Per-pair request lines |
| ack | input | NUM_PAIRS | Per-pair pending acknowledge |
| sel_a | output | NUM_PAIRS | Packet A active per pair |
| sel_b | output | NUM_PAIRS | Packet B active per pair |
| pend | output | NUM_PAIRS | Pending request per pair |

## Verification
The write commands are tried as uniform words (all 01, all 10, all 11, all 00) and as mixed random words. Uniform words show that each code reaches every pair. Mixed words show that pairs are decoded independently and that the code does not leak into neighbouring bits. The pending logic is tried with requests that come before, together with, and after an enabling write, and also across an A/B switch. These cases separate the clear-on-start rule from the keep-on-switch rule and from the same-cycle exception. Collisions of auto-disable with writes, and unprivileged or misaddressed writes, are mixed into a long random run. That run shows the priority order and that the guarded writes do nothing.

// File: rtl/pcer_pkg.sv
package pcer_pkg;

  typedef enum logic [1:0] {
    PAIR_OFF = 2'b00,
    PAIR_A   = 2'b01,
    PAIR_B   = 2'b10
  } pair_st_t;

  // Command encoding: 00 hold, 01 select A, 10 select B, 11 off
  function automatic pair_st_t apply_cmd(input pair_st_t cur, input logic [1:0] cmd);
    pair_st_t res;
    case (cmd)
      2'b01:   res = PAIR_A;
      2'b10:   res = PAIR_B;
      2'b11:   res = PAIR_OFF;
      default: res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pcer_bus_decode.sv
module pcer_bus_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;

  assign addr_match = (bus_addr == REG_ADDR);
  // writes need privilege, reads do not
  assign wr_hit = bus_wr & bus_priv & addr_match;
  assign rd_hit = bus_rd & addr_match;
endmodule

// File: rtl/pcer_pair_cell.sv
module pcer_pair_cell
  import pcer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [1:0] cmd,
  input  logic       auto_dis,
  input  logic       req,
  input  logic       ack,
  output logic       sel_a,
  output logic       sel_b,
  output logic       pend
);
  pair_st_t st_q, st_d;
  logic     pend_q, pend_d;
  logic     start;

  always_comb begin
    st_d = st_q;
    if (auto_dis)
      st_d = PAIR_OFF;
    else if (wr_hit)
      st_d = apply_cmd(st_q, cmd);
  end

  // leaving the fully-off state through a register write
  assign start = wr_hit && !auto_dis && (st_q == PAIR_OFF) && (st_d != PAIR_OFF);

  always_comb begin
    pend_d = pend_q;
    if (req)
      pend_d = 1'b1;
    else if (start || ack)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PAIR_OFF;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign sel_a = st_q[0];
  assign sel_b = st_q[1];
  assign pend  = pend_q;
endmodule

// File: rtl/pcer_read_port.sv
module pcer_read_port #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_hit,
  input  logic [FIELD_W-1:0] field,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_W = DATA_W - FIELD_W;

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_hit)
      rdata <= {{PAD_W{1'b0}}, field};
    else
      rdata <= '0;
  end
endmodule

// File: rtl/pair_enable_reg.sv
module pair_enable_reg #(
  parameter int NUM_PAIRS = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_priv,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PAIRS-1:0] auto_dis,
  input  logic [NUM_PAIRS-1:0] req,
  input  logic [NUM_PAIRS-1:0] ack,
  output logic [NUM_PAIRS-1:0] sel_a,
  output logic [NUM_PAIRS-1:0] sel_b,
  output logic [NUM_PAIRS-1:0] pend
);
  localparam int FIELD_W = 2 * NUM_PAIRS;

  logic               wr_hit, rd_hit;
  logic [FIELD_W-1:0] field;

  pcer_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    pcer_pair_cell u_cell (
      .clk(clk), .rst(rst), .wr_hit(wr_hit),
      .cmd(bus_wdata[2*i +: 2]), .auto_dis(auto_dis[i]),
      .req(req[i]), .ack(ack[i]),
      .sel_a(sel_a[i]), .sel_b(sel_b[i]), .pend(pend[i])
    );
    assign field[2*i]   = sel_a[i];
    assign field[2*i+1] = sel_b[i];
  end

  pcer_read_port #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .field(field), .rdata(bus_rdata)
  );

  // bus_wdata above the command field is deliberately left unread
  logic unused_hi;
  assign unused_hi = ^bus_wdata[DATA_W-1:FIELD_W];
endmodule

// File: rtl/pcer_chk.sv
module pcer_chk #(
  parameter int NUM_PAIRS = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_priv,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_PAIRS-1:0] auto_dis,
  input logic [NUM_PAIRS-1:0] req,
  input logic [NUM_PAIRS-1:0] ack,
  input logic [NUM_PAIRS-1:0] sel_a,
  input logic [NUM_PAIRS-1:0] sel_b,
  input logic [NUM_PAIRS-1:0] pend
);
  localparam int FIELD_W = 2 * NUM_PAIRS;

  logic                 wr_ok;
  logic [NUM_PAIRS-1:0] start_v, swap_v;

  assign wr_ok = bus_wr && bus_priv && (bus_addr == REG_ADDR);

  always_comb begin
    for (int i = 0; i < NUM_PAIRS; i++) begin
      start_v[i] = wr_ok && !auto_dis[i] && !req[i] && !sel_a[i] && !sel_b[i] &&
                   (bus_wdata[2*i +: 2] == 2'b01 || bus_wdata[2*i +: 2] == 2'b10);
      swap_v[i]  = wr_ok && !auto_dis[i] && !ack[i] && pend[i] &&
                   ((sel_a[i] && bus_wdata[2*i +: 2] == 2'b10) ||
                    (sel_b[i] && bus_wdata[2*i +: 2] == 2'b01));
    end
  end

  // R3
  one_pkt_chk: assert property (@(posedge clk) disable iff (rst) (sel_a & sel_b) == '0);

  // R4
  rdata_hi_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:FIELD_W] == '0);

  // R5
  nopriv_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_priv && auto_dis == '0) |=> ($stable(sel_a) && $stable(sel_b)));

  // R6
  auto_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_dis != '0) |=> (((sel_a | sel_b) & $past(auto_dis)) == '0));

  // R7
  req_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> ((pend & $past(req)) == $past(req)));

  // R8
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (start_v != '0) |=> ((pend & $past(start_v)) == '0));

  // R9
  swap_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (swap_v != '0) |=> ((pend & $past(swap_v)) == $past(swap_v)));
endmodule

bind pair_enable_reg pcer_chk #(
  .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .auto_dis(auto_dis), .req(req),
  .ack(ack), .sel_a(sel_a), .sel_b(sel_b), .pend(pend)
);

// File: tb/test_pair_enable_reg.sv
module test_pair_enable_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] RA = 8'h04;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr, bus_rd, bus_priv;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [NP-1:0] auto_dis, req, ack, sel_a, sel_b, pend;

  logic [NP-1:0] m_a, m_b, m_p;
  logic [DW-1:0] m_rd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_enable_reg #(.NUM_PAIRS(NP), .ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) i_pair_enable_reg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .auto_dis(auto_dis), .req(req), .ack(ack),
    .sel_a(sel_a), .sel_b(sel_b), .pend(pend)
  );

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "sel_a", DW'(sel_a), DW'(m_a));
    cmp(tag, "sel_b", DW'(sel_b), DW'(m_b));
    cmp(tag, "pend", DW'(pend), DW'(m_p));
    cmp(tag, "rdata", bus_rdata, m_rd);
  endtask

  // Reference model from the requirements; called before the edge with old state
  task automatic model_step();
    logic [NP-1:0] na, nb, np_;
    logic hit;
    hit = bus_wr && bus_priv && (bus_addr == RA);
    m_rd = '0;
    if (bus_rd && bus_addr == RA)
      for (int i = 0; i < NP; i++) begin
        m_rd[2*i] = m_a[i];
        m_rd[2*i+1] = m_b[i];
      end
    for (int i = 0; i < NP; i++) begin
      logic [1:0] c;
      logic st;
      c = bus_wdata[2*i +: 2];
      na[i] = m_a[i]; nb[i] = m_b[i];
      if (auto_dis[i]) begin
        na[i] = 0; nb[i] = 0;                       // R6
      end else if (hit) begin
        if (c == 2'b01) begin na[i] = 1; nb[i] = 0; end  // R2
        else if (c == 2'b10) begin na[i] = 0; nb[i] = 1; end
        else if (c == 2'b11) begin na[i] = 0; nb[i] = 0; end
      end
      st = hit && !auto_dis[i] && !m_a[i] && !m_b[i] && (na[i] || nb[i]);
      np_[i] = m_p[i];
      if (req[i]) np_[i] = 1;                        // R7, R10
      else if (st || ack[i]) np_[i] = 0;             // R8
    end
    m_a = na; m_b = nb; m_p = np_;
  endtask

  task automatic idle_in();
    bus_wr = 0; bus_rd = 0; bus_priv = 0; bus_addr = '0; bus_wdata = '0;
    auto_dis = '0; req = '0; ack = '0;
  endtask

  // one cycle: inputs already driven at negedge; check after the edge
  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    idle_in();
  endtask

  task automatic wr(input logic priv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input string tag);
    bus_wr = 1; bus_priv = priv; bus_addr = a; bus_wdata = d;
    step(tag);
  endtask

  task automatic rd(input string tag);
    bus_rd = 1; bus_addr = RA;
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in();
    rst = 1;
    m_a = '0; m_b = '0; m_p = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_all("R1");                                 // R1 reset state

    wr(1, RA, 32'h0000_5555, "R2");                  // all pairs -> A
    rd("R3");
    wr(1, RA, 32'h0000_AAAA, "R2");                  // all pairs -> B
    rd("R3");
    wr(1, RA, 32'h0000_0000, "R2");                  // hold
    wr(1, RA, 32'h0000_1B6C, "R2");                  // mixed codes
    rd("R3");
    wr(1, RA, 32'hFFFF_0000, "R4");                  // upper bits ignored
    bus_rd = 1; bus_addr = RA + 8'h04; step("R4");   // other address reads 0
    wr(0, RA, 32'h0000_FFFF, "R5");                  // unprivileged ignored
    wr(1, RA + 8'h08, 32'h0000_FFFF, "R5");          // wrong address ignored
    bus_rd = 1; bus_priv = 0; bus_addr = RA; step("R5"); // read without privilege
    wr(1, RA, 32'h0000_FFFF, "R2");                  // all off

    // R6: auto-disable beats a write in the same cycle
    wr(1, RA, 32'h0000_5555, "R2");
    auto_dis = 8'h0F; bus_wr = 1; bus_priv = 1; bus_addr = RA; bus_wdata = 32'h0000_AAAA;
    step("R6");
    rd("R6");

    // R7: request while off latches; ack clears; req beats ack
    wr(1, RA, 32'h0000_FFFF, "R2");
    req = 8'h03; step("R7");
    ack = 8'h01; step("R7");
    req = 8'h02; ack = 8'h02; step("R7");
    // R8: enabling from off discards stale request
    req = 8'h01; step("R7");
    wr(1, RA, 32'h0000_0005, "R8");
    // R10: request together with enabling write is kept
    req = 8'h04; bus_wr = 1; bus_priv = 1; bus_addr = RA; bus_wdata = 32'h0000_0020;
    step("R10");
    // R9: switch A<->B keeps pending
    req = 8'h03; step("R7");
    wr(1, RA, 32'h0000_0026, "R9");
    wr(1, RA, 32'h0000_0019, "R9");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      bus_wr   = ($urandom % 3) != 0;
      bus_rd   = ($urandom % 2) != 0;
      bus_priv = ($urandom % 5) != 0;
      bus_addr = (r == 0) ? AW'($urandom) : RA;
      bus_wdata = $urandom;
      auto_dis = ($urandom % 4 == 0) ? NP'($urandom) : '0;
      req      = NP'($urandom) & NP'($urandom);
      ack      = NP'($urandom) & NP'($urandom);
      step("RND R2 R5 R6 R7 R8 R9 R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule